// File: doc/BRIEF.md
# List-Filled Command Status Controller

This block holds the command/status word of a host controller that walks two lists of transfer descriptors: a control list and a bulk list. Software reaches the word over a simple single-register write/read port. It can set a "list filled" flag for either list, and it can start a soft reset through a bit that clears itself. A list walker reports three kinds of event for each list: the start of a pass at the list head, a descriptor found during the pass, and the end of the pass. From these events the block decides whether a pass runs and whether processing of that list continues.

Each filled flag is a handshake that software and hardware share. When a pass begins on a set flag, hardware clears the flag. Every descriptor found during the pass sets the flag again. If the flag is still clear when the pass ends, processing of that list stops. A soft reset holds the block quiet for a fixed number of cycles, clears the list state and puts the controller into its suspend state.

Top module: `lfcs_top`

## Requirements
- R1: After a hardware reset, the read word is 0, `srst_busy_o` and `suspend_o` are 0, and no pass runs or continues.
- R2: In the read word, bit 0 is the soft-reset bit, which reads 1 exactly while `srst_busy_o` is high. Bit 1 is the control-list flag and bit 2 is the bulk-list flag. Bits 31..3 always read 0, and writes to them are ignored.
- R3: A write with bit 1 (control) or bit 2 (bulk) at 1 sets that flag from the next cycle. Writing 0 to a flag leaves it unchanged.
- R4: A pass start on a list whose flag is 0 leaves `pass_run_o` low for that list (index 0 = control, 1 = bulk), and the flag stays 0.
- R5: A pass start on a list whose flag is 1 raises `pass_run_o` for that list in the same cycle, and the flag reads 0 from the next cycle unless it is set again in that same cycle.
- R6: A descriptor found while that list's pass is active sets its flag from the next cycle. A descriptor reported outside an active pass has no effect.
- R7: On a pass end of an active pass, `pass_cont_o` for that list is high in that cycle exactly when the flag, including sets made in that same cycle, is 1. The pass is then no longer active.
- R8: If a software set and a pass-start clear meet on the same flag in the same cycle, the flag ends at 1.
- R9: A write with bit 0 at 1 starts a soft reset, and this takes priority over flag bits in the same write. `srst_busy_o` is then high for exactly RST_CYCLES cycles, capped at CLK_MHZ×MAX_US cycles, and afterwards falls by itself. Both flags and both pass states are cleared.
- R10: While `srst_busy_o` is high, register writes, walker events and `run_req_i` are ignored, and `pass_run_o` and `pass_cont_o` stay 0.
- R11: `suspend_o` rises when a soft reset starts. It stays high until `run_req_i` is seen while no soft reset is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| csr_wr_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read value |
| pass_start_i | input | 2 | Walker reached the list head (bit 0 control, bit 1 bulk) |
| desc_found_i | input | 2 | Walker found a descriptor on the list |
| pass_end_i | input | 2 | Walker finished the pass on the list |
| run_req_i | input | 1 | Request to leave the suspend state |
| pass_run_o | output | 2 | Pass at this start is processed |
| pass_cont_o | output | 2 | At pass end, processing of the list continues |
| srst_busy_o | output | 1 | Soft reset in progress; host bus accesses are held off |
| suspend_o | output | 1 | Controller is in the suspend state |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a software set landing in the cycle where a pass start clears the flag. Another is a set arriving in the same cycle as a pass end, which decides whether processing continues. The stimulus drives these events together in one step, on both lists. A further hard case is a soft reset written together with flag bits, followed by writes, walker events and resume requests during the busy window. Each of these must leave no trace, which the per-cycle comparison with the bench's reference model reveals.

// File: rtl/lfcs_pkg.sv
package lfcs_pkg;
  localparam int REG_W    = 32;
  localparam int N_LISTS  = 2;
  localparam int BIT_SRST = 0;
  localparam int BIT_LIST = 1;  // first list flag; list i sits at BIT_LIST+i

  // Upper bound on reset cycles for a given clock and time limit.
  function automatic int srst_limit(input int clk_mhz, input int max_us);
    return clk_mhz * max_us;
  endfunction

  function automatic int srst_len(input int req, input int lim);
    return (req > lim) ? lim : ((req < 1) ? 1 : req);
  endfunction

  // Flag value after one cycle of events; later terms win.
  function automatic logic flag_next(input logic cur, input logic clr_on_run,
                                     input logic hw_set, input logic sw_set);
    logic v;
    v = cur;
    if (clr_on_run) v = 1'b0;
    if (hw_set)     v = 1'b1;
    if (sw_set)     v = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/lfcs_flag.sv
module lfcs_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic quiet_i,
  input  logic clr_i,
  input  logic sw_set_i,
  input  logic start_i,
  input  logic found_i,
  input  logic end_i,
  output logic flag_o,
  output logic run_o,
  output logic cont_o,
  output logic active_o
);
  logic flag_q, active_q, found_ok, flag_evt;

  assign run_o    = start_i & flag_q & ~quiet_i;
  assign found_ok = found_i & active_q & ~quiet_i;
  assign flag_evt = lfcs_pkg::flag_next(flag_q, run_o, found_ok, sw_set_i & ~quiet_i);
  assign cont_o   = end_i & active_q & ~quiet_i & flag_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      active_q <= 1'b0;
    end else if (clr_i) begin
      flag_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      flag_q <= flag_evt;
      if (run_o)      active_q <= 1'b1;
      else if (end_i) active_q <= 1'b0;
    end
  end

  assign flag_o   = flag_q;
  assign active_o = active_q;
endmodule

// File: rtl/lfcs_srst.sv
module lfcs_srst #(
  parameter int LEN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_req_i,
  output logic busy_o,
  output logic suspend_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, susp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      susp_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
      susp_q <= 1'b1;
    end else if (run_req_i) begin
      susp_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign suspend_o = susp_q;
endmodule

// File: rtl/lfcs_top.sv
module lfcs_top #(
  parameter int CLK_MHZ    = 100,
  parameter int MAX_US     = 10,
  parameter int RST_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr_i,
  input  logic [31:0] csr_wdata_i,
  output logic [31:0] csr_rdata_o,
  input  logic [1:0]  pass_start_i,
  input  logic [1:0]  desc_found_i,
  input  logic [1:0]  pass_end_i,
  input  logic        run_req_i,
  output logic [1:0]  pass_run_o,
  output logic [1:0]  pass_cont_o,
  output logic        srst_busy_o,
  output logic        suspend_o
);
  import lfcs_pkg::*;

  localparam int RST_LIMIT = srst_limit(CLK_MHZ, MAX_US);
  localparam int RST_EFF   = srst_len(RST_CYCLES, RST_LIMIT);

  logic                srst_start;
  logic                busy;
  logic [N_LISTS-1:0]  list_flag;
  logic [N_LISTS-1:0]  list_active;
  logic [N_LISTS-1:0]  sw_set;
  logic                unused_wbits;

  assign unused_wbits = ^csr_wdata_i[REG_W-1:BIT_LIST+N_LISTS];
  assign srst_start   = csr_wr_i & csr_wdata_i[BIT_SRST] & ~busy;

  lfcs_srst #(.LEN(RST_EFF)) u_srst (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (srst_start),
    .run_req_i (run_req_i),
    .busy_o    (busy),
    .suspend_o (suspend_o)
  );

  for (genvar g = 0; g < N_LISTS; g++) begin : g_list
    assign sw_set[g] = csr_wr_i & csr_wdata_i[BIT_LIST+g];
    lfcs_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .quiet_i  (busy),
      .clr_i    (srst_start | busy),
      .sw_set_i (sw_set[g]),
      .start_i  (pass_start_i[g]),
      .found_i  (desc_found_i[g]),
      .end_i    (pass_end_i[g]),
      .flag_o   (list_flag[g]),
      .run_o    (pass_run_o[g]),
      .cont_o   (pass_cont_o[g]),
      .active_o (list_active[g])
    );
  end

  always_comb begin
    csr_rdata_o = '0;
    csr_rdata_o[BIT_SRST] = busy;
    csr_rdata_o[BIT_LIST +: N_LISTS] = list_flag;
  end

  assign srst_busy_o = busy;
endmodule

// File: rtl/lfcs_chk.sv
module lfcs_chk #(
  parameter int LEN = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_wr_i,
  input logic [31:0] csr_wdata_i,
  input logic [31:0] csr_rdata_o,
  input logic [1:0]  pass_start_i,
  input logic [1:0]  desc_found_i,
  input logic [1:0]  pass_run_o,
  input logic [1:0]  pass_cont_o,
  input logic [1:0]  list_active,
  input logic        srst_busy_o,
  input logic        suspend_o
);
  localparam int CW = $clog2(LEN + 2);
  logic [CW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           busy_len <= '0;
    else if (srst_busy_o) busy_len <= busy_len + 1'b1;
    else                  busy_len <= '0;
  end

  p_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_start_i[0] && !csr_rdata_o[1]) |-> !pass_run_o[0]);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_run_o[0] && !csr_wr_i && !desc_found_i[0]) |=> !csr_rdata_o[1]);

  p_found_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_found_i[1] && list_active[1] && !srst_busy_o &&
     !(csr_wr_i && csr_wdata_i[0])) |=> csr_rdata_o[2]);

  p_setwins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_run_o[1] && csr_wr_i && csr_wdata_i[2] && !csr_wdata_i[0]) |=> csr_rdata_o[2]);

  p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_busy_o) |-> (csr_rdata_o[2:1] == 2'b00));

  p_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_busy_o) |-> (busy_len == CW'(LEN)));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy_o |-> (pass_run_o == 2'b00 && pass_cont_o == 2'b00));

  p_susp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_busy_o) |-> suspend_o);
endmodule

bind lfcs_top lfcs_chk #(.LEN(RST_EFF)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_wr_i     (csr_wr_i),
  .csr_wdata_i  (csr_wdata_i),
  .csr_rdata_o  (csr_rdata_o),
  .pass_start_i (pass_start_i),
  .desc_found_i (desc_found_i),
  .pass_run_o   (pass_run_o),
  .pass_cont_o  (pass_cont_o),
  .list_active  (list_active),
  .srst_busy_o  (srst_busy_o),
  .suspend_o    (suspend_o)
);

// File: tb/lfcs_top_tb.sv
module lfcs_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RST_LEN    = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic [1:0]  pass_start_i = '0, desc_found_i = '0, pass_end_i = '0;
  logic        run_req_i = 1'b0;
  logic [1:0]  pass_run_o, pass_cont_o;
  logic        srst_busy_o, suspend_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int m_flag[2];
  int m_act[2];
  int m_busy, m_left, m_susp;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfcs_top #(.RST_CYCLES(RST_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_wr_i(csr_wr_i), .csr_wdata_i(csr_wdata_i),
    .csr_rdata_o(csr_rdata_o), .pass_start_i(pass_start_i),
    .desc_found_i(desc_found_i), .pass_end_i(pass_end_i), .run_req_i(run_req_i),
    .pass_run_o(pass_run_o), .pass_cont_o(pass_cont_o),
    .srst_busy_o(srst_busy_o), .suspend_o(suspend_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int nxt_flag(input int i);
    int v = m_flag[i];
    if (m_busy != 0) return 0;
    if (pass_start_i[i] && m_flag[i] != 0) v = 0;
    if (desc_found_i[i] && m_act[i] != 0) v = 1;
    if (csr_wr_i && csr_wdata_i[1+i]) v = 1;
    return v;
  endfunction

  task automatic compare();
    logic [31:0] e_rd = '0;
    e_rd[0] = (m_busy != 0);
    e_rd[1] = (m_flag[0] != 0);
    e_rd[2] = (m_flag[1] != 0);
    chk("R2", "read word", csr_rdata_o, e_rd);
    for (int i = 0; i < 2; i++) begin
      chk("R5", "pass_run", pass_run_o[i],
          (m_busy == 0 && pass_start_i[i] && m_flag[i] != 0));
      chk("R7", "pass_cont", pass_cont_o[i],
          (m_busy == 0 && pass_end_i[i] && m_act[i] != 0 && nxt_flag(i) != 0));
    end
    chk("R9", "busy", srst_busy_o, m_busy != 0);
    chk("R11", "suspend", suspend_o, m_susp != 0);
  endtask

  task automatic model_update();
    int nf[2];
    int na[2];
    for (int i = 0; i < 2; i++) begin
      nf[i] = nxt_flag(i);
      na[i] = m_act[i];
      if (m_busy == 0) begin
        if (pass_start_i[i] && m_flag[i] != 0) na[i] = 1;
        else if (pass_end_i[i]) na[i] = 0;
      end
    end
    if (m_busy != 0) begin
      m_left--;
      if (m_left == 0) m_busy = 0;
      nf[0] = 0; nf[1] = 0; na[0] = 0; na[1] = 0;
    end else if (csr_wr_i && csr_wdata_i[0]) begin
      m_busy = 1; m_left = RST_LEN; m_susp = 1;
      nf[0] = 0; nf[1] = 0; na[0] = 0; na[1] = 0;
    end else if (run_req_i) begin
      m_susp = 0;
    end
    for (int i = 0; i < 2; i++) begin
      m_flag[i] = nf[i];
      m_act[i]  = na[i];
    end
  endtask

  // one clock: drive at negedge, compare, then update model at posedge
  task automatic step(input logic wr, input logic [31:0] wd, input logic [1:0] st,
                      input logic [1:0] fd, input logic [1:0] en, input logic rr);
    csr_wr_i = wr; csr_wdata_i = wd; pass_start_i = st;
    desc_found_i = fd; pass_end_i = en; run_req_i = rr;
    #1;
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, '0, 2'b00, 2'b00, 2'b00, 1'b0);
  endtask

  initial begin
    m_flag[0] = 0; m_flag[1] = 0; m_act[0] = 0; m_act[1] = 0;
    m_busy = 0; m_left = 0; m_susp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "read word after reset", csr_rdata_o, 0);
    chk("R1", "suspend after reset", suspend_o, 0);
    idle(2);
    // R4: start on empty control list is skipped
    step(1'b0, '0, 2'b01, 2'b00, 2'b00, 1'b0);
    step(1'b0, '0, 2'b00, 2'b00, 2'b01, 1'b0);
    // R3: writing zero has no effect; R2: reserved bits ignored
    step(1'b1, 32'h0000_0000, 2'b00, 2'b00, 2'b00, 1'b0);
    step(1'b1, 32'hFFFF_FFF8, 2'b00, 2'b00, 2'b00, 1'b0);
    idle(1);
    // R3 set control flag, R5 run, R6 found, R7 continue
    step(1'b1, 32'h2, 2'b00, 2'b00, 2'b00, 1'b0);
    step(1'b0, '0, 2'b01, 2'b00, 2'b00, 1'b0);
    step(1'b0, '0, 2'b00, 2'b01, 2'b00, 1'b0);
    step(1'b0, '0, 2'b00, 2'b00, 2'b01, 1'b0);
    // R7 stop: pass with no descriptor
    step(1'b0, '0, 2'b01, 2'b00, 2'b00, 1'b0);
    idle(1);
    step(1'b0, '0, 2'b00, 2'b00, 2'b01, 1'b0);
    // R6: found outside active pass is ignored
    step(1'b0, '0, 2'b00, 2'b11, 2'b00, 1'b0);
    idle(1);
    // R8: software set collides with pass-start clear on bulk list
    step(1'b1, 32'h4, 2'b00, 2'b00, 2'b00, 1'b0);
    step(1'b1, 32'h4, 2'b10, 2'b00, 2'b00, 1'b0);
    step(1'b0, '0, 2'b00, 2'b00, 2'b10, 1'b0);
    // R8 on control list, then R7 set arriving with pass end
    step(1'b1, 32'h2, 2'b00, 2'b00, 2'b00, 1'b0);
    step(1'b1, 32'h2, 2'b01, 2'b00, 2'b00, 1'b0);
    step(1'b0, '0, 2'b01, 2'b00, 2'b00, 1'b0);
    step(1'b1, 32'h2, 2'b00, 2'b00, 2'b01, 1'b0);
    // both lists together
    step(1'b0, '0, 2'b11, 2'b00, 2'b00, 1'b0);
    step(1'b0, '0, 2'b00, 2'b10, 2'b00, 1'b0);
    step(1'b0, '0, 2'b00, 2'b00, 2'b11, 1'b0);
    // R9: soft reset written with flag bits; reset wins
    step(1'b1, 32'h6, 2'b00, 2'b00, 2'b00, 1'b0);
    step(1'b1, 32'h7, 2'b00, 2'b00, 2'b00, 1'b0);
    // R10: writes, events and run requests ignored while busy
    step(1'b1, 32'h7, 2'b11, 2'b11, 2'b11, 1'b1);
    step(1'b1, 32'h6, 2'b11, 2'b00, 2'b00, 1'b0);
    step(1'b0, '0, 2'b00, 2'b00, 2'b00, 1'b1);
    idle(RST_LEN);
    // R11: leave suspend with a run request
    step(1'b0, '0, 2'b00, 2'b00, 2'b00, 1'b1);
    idle(1);
    step(1'b1, 32'h2, 2'b00, 2'b00, 2'b00, 1'b0);
    step(1'b0, '0, 2'b01, 2'b00, 2'b00, 1'b0);
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule